// File: doc/BRIEF.md
# Optical Path Reservation Controller

This block hands out whole circuit-switched optical paths through a binary tree of optical routers to the cluster concentrators below it. A concentrator posts a request naming a destination cluster. Its own index is the source. The request waits in a slot inside the controller. On every clock the controller runs one arbitration round. It visits the waiting requests in rotating order and works out each one's link set from the destination. A request wins when none of its links is held, and none is claimed by an earlier winner of the same round. Winners claim their links in the link-state register and receive a grant. The source starts its data only after the grant. When the data is done it pulses teardown, and every link of its path is released.

A request whose destination is its own cluster is carried by the local electrical crossbar. It still passes through a slot and receives a grant, but its link set is empty, so it never claims an optical link. A request whose path is blocked is never dropped. It is retried on every round until the links come free.

The request input is a valid/ready stream, one per concentrator. A request is taken only on a clock edge where both valid and ready are high, and the destination is sampled on that edge alone. Ready is low while the concentrator has a request waiting or a path held. A source may hold or drop valid while ready is low. Nothing is recorded until the handshake completes. Teardown, grant and the link-state view are plain signals.

Top module: `path_rsv_ctrl`

## Requirements
- R1: After reset every bit of `link_busy` is 0, `grant` is 0 and every `req_ready` bit is 1.
- R2: `req_ready[c]` is 0 from the edge that takes a request from concentrator c until the edge that grants it, and then until the edge that takes its teardown. Valid from a concentrator whose `req_ready` is 0 has no effect on grants or link state.
- R3: With N clusters and `off(i) = 2N - 2*(N>>i)`, a path from s to d uses two links at each level i (0 <= i < log2 N) where `s>>i != d>>i`. The upward link is bit `off(i) + (s>>i)` of `link_busy`. The downward link is bit `2N-2 + off(i) + (d>>i)`. If a request is taken at edge k and its links are free, `grant[s]` and those link bits are high after edge k+1.
- R4: A request whose destination equals its source is granted one edge after it is taken and sets no bit of `link_busy`.
- R5: A request whose links are held stays waiting and is retried every round. A teardown releases its links on the same edge where a waiting request may claim them.
- R6: Two requests in the same round that share a link are never both granted. Requests with disjoint link sets are granted in the same round.
- R7: A teardown from a concentrator holding a path clears exactly that path's link bits on the edge it is sampled. A teardown from a concentrator that holds no path changes nothing.
- R8: Each grant is high for exactly one cycle.
- R9: Each round visits concentrators in index order, wrapping around, starting one after the last concentrator granted by the most recent round that granted anything. Concentrator 0 is visited first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_CLUSTER | Request valid, one bit per concentrator |
| req_ready | output | N_CLUSTER | Request slot free, one bit per concentrator |
| req_dst | input | N_CLUSTER*log2(N_CLUSTER) | Destination cluster; concentrator c uses bits [c*W +: W] |
| teardown | input | N_CLUSTER | One-cycle pulse ending the concentrator's path |
| grant | output | N_CLUSTER | One-cycle grant pulse per concentrator |
| link_busy | output | 4*N_CLUSTER-4 | Link-state register, one bit per directed tree link |

## Verification
A request taken at edge k shows up as a grant and its link bits after edge k+1, and `req_ready` drops after edge k. A teardown sampled at edge t clears its links after edge t. A request that waited on those links is granted after that same edge t. The bench drives inputs on the falling edge and samples outputs on the next falling edge, after the register has updated once. Its reference model advances on the same rising edge as the design, so each compare lines up with the cycle in which every result is due.

// File: rtl/path_rsv_pkg.sv
package path_rsv_pkg;

  // Start index of tree level lvl inside one direction's link group.
  function automatic int lvl_off(input int n, input int lvl);
    return 2 * n - 2 * (n >> lvl);
  endfunction

  // Directed links in a binary tree of n leaves (up plus down).
  function automatic int link_cnt(input int n);
    return 4 * n - 4;
  endfunction

endpackage

// File: rtl/path_rsv_route.sv
module path_rsv_route
  import path_rsv_pkg::*;
#(
  parameter int N   = 8,
  parameter int SRC = 0
) (
  input  logic [$clog2(N)-1:0] dst,
  output logic [4*N-5:0]       links
);
  localparam int W   = $clog2(N);
  localparam int NUP = 2 * N - 2;
  localparam logic [W-1:0] S = W'(SRC);

  always_comb begin
    links = '0;
    for (int lv = 0; lv < W; lv++) begin
      if ((S >> lv) != (dst >> lv)) begin
        links[lvl_off(N, lv) + int'(S >> lv)]         = 1'b1;
        links[NUP + lvl_off(N, lv) + int'(dst >> lv)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/path_rsv_slot.sv
module path_rsv_slot #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [W-1:0] req_dst,
  input  logic         teardown,
  input  logic         win,
  output logic         req_ready,
  output logic         pend,
  output logic         act,
  output logic [W-1:0] dst,
  output logic         drop
);
  logic         pend_q, act_q;
  logic [W-1:0] dst_q;

  assign req_ready = !pend_q && !act_q;
  assign drop      = teardown && act_q;
  assign pend      = pend_q;
  assign act       = act_q;
  assign dst       = dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      dst_q  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        pend_q <= 1'b1;
        dst_q  <= req_dst;
      end else if (win) begin
        pend_q <= 1'b0;
      end
      if (win) begin
        act_q <= 1'b1;
      end else if (drop) begin
        act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/path_rsv_arb.sv
module path_rsv_arb #(
  parameter int N  = 8,
  parameter int NL = 28
) (
  input  logic [N-1:0]          pend,
  input  logic [N-1:0][NL-1:0]  routes,
  input  logic [NL-1:0]         held,
  input  logic [$clog2(N)-1:0]  ptr,
  output logic [N-1:0]          win,
  output logic [NL-1:0]         next_busy,
  output logic [$clog2(N)-1:0]  last,
  output logic                  any_win
);
  localparam int W = $clog2(N);

  logic [NL-1:0] used;
  logic [W-1:0]  idx;

  always_comb begin
    win  = '0;
    used = held;
    last = ptr;
    idx  = ptr;
    for (int k = 1; k <= N; k++) begin
      idx = ptr + W'(k);
      if (pend[idx] && ((routes[idx] & used) == '0)) begin
        win[idx] = 1'b1;
        used     = used | routes[idx];
        last     = idx;
      end
    end
    next_busy = used;
    any_win   = |win;
  end
endmodule

// File: rtl/path_rsv_ctrl.sv
module path_rsv_ctrl
  import path_rsv_pkg::*;
#(
  parameter int N_CLUSTER = 8,
  localparam int W  = $clog2(N_CLUSTER),
  localparam int NL = 4 * N_CLUSTER - 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CLUSTER-1:0]   req_valid,
  output logic [N_CLUSTER-1:0]   req_ready,
  input  logic [N_CLUSTER*W-1:0] req_dst,
  input  logic [N_CLUSTER-1:0]   teardown,
  output logic [N_CLUSTER-1:0]   grant,
  output logic [NL-1:0]          link_busy
);
  logic [N_CLUSTER-1:0]         pend_w, act_w, drop_w, win_w;
  logic [N_CLUSTER-1:0][W-1:0]  dst_w;
  logic [N_CLUSTER-1:0][NL-1:0] route_w;
  logic [NL-1:0]                freed, held, next_busy, busy_q;
  logic [W-1:0]                 ptr_q, last_w;
  logic [N_CLUSTER-1:0]         grant_q;
  logic                         any_w;

  for (genvar g = 0; g < N_CLUSTER; g++) begin : g_conc
    path_rsv_slot #(.W(W)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[g]),
      .req_dst   (req_dst[g*W +: W]),
      .teardown  (teardown[g]),
      .win       (win_w[g]),
      .req_ready (req_ready[g]),
      .pend      (pend_w[g]),
      .act       (act_w[g]),
      .dst       (dst_w[g]),
      .drop      (drop_w[g])
    );
    path_rsv_route #(.N(N_CLUSTER), .SRC(g)) route_i (
      .dst   (dst_w[g]),
      .links (route_w[g])
    );
  end

  // Links of paths torn down this cycle are free before the round runs.
  always_comb begin
    freed = '0;
    for (int i = 0; i < N_CLUSTER; i++) begin
      if (drop_w[i]) freed = freed | route_w[i];
    end
  end

  assign held = busy_q & ~freed;

  path_rsv_arb #(.N(N_CLUSTER), .NL(NL)) arb_i (
    .pend      (pend_w),
    .routes    (route_w),
    .held      (held),
    .ptr       (ptr_q),
    .win       (win_w),
    .next_busy (next_busy),
    .last      (last_w),
    .any_win   (any_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      grant_q <= '0;
      ptr_q   <= W'(N_CLUSTER - 1);
    end else begin
      busy_q  <= next_busy;
      grant_q <= win_w;
      if (any_w) ptr_q <= last_w;
    end
  end

  assign grant     = grant_q;
  assign link_busy = busy_q;
endmodule

// File: rtl/path_rsv_chk.sv
module path_rsv_chk #(
  parameter int N  = 8,
  parameter int NL = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_ready,
  input logic [N-1:0]  teardown,
  input logic [N-1:0]  grant,
  input logic [NL-1:0] link_busy
);
  for (genvar g = 0; g < N; g++) begin : g_c
    a_r8_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |=> !grant[g]);
    a_r2_held_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |-> !req_ready[g]);
  end

  a_r3_claim_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_busy & ~$past(link_busy)) != '0) |-> (grant != '0));

  a_r7_free_needs_teardown: assert property (@(posedge clk) disable iff (!rst_n)
    ((~link_busy & $past(link_busy)) != '0) |-> ($past(teardown) != '0));
endmodule

bind path_rsv_ctrl path_rsv_chk #(.N(N_CLUSTER), .NL(NL)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .teardown  (teardown),
  .grant     (grant),
  .link_busy (link_busy)
);

// File: tb/path_rsv_ctrl_tb_top.sv
module path_rsv_ctrl_tb_top;
  localparam int N   = 8;
  localparam int W   = 3;
  localparam int NL  = 4 * N - 4;
  localparam int NUP = 2 * N - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0;
  logic [N-1:0]  req_ready;
  logic [N*W-1:0] req_dst = '0;
  logic [N-1:0]  teardown = '0;
  logic [N-1:0]  grant;
  logic [NL-1:0] link_busy;

  int n_run = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  path_rsv_ctrl #(.N_CLUSTER(N)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_dst (req_dst), .teardown (teardown), .grant (grant), .link_busy (link_busy)
  );

  // Reference model
  bit            m_pend[N];
  bit            m_act[N];
  int            m_dst[N];
  logic [NL-1:0] m_busy;
  logic [N-1:0]  m_gnt;
  int            m_ptr;

  function automatic logic [NL-1:0] m_route(input int s, input int d);
    logic [NL-1:0] r = '0;
    for (int lv = 0; lv < W; lv++) begin
      if ((s >> lv) != (d >> lv)) begin
        r[2*N - 2*(N >> lv) + (s >> lv)]       = 1'b1;
        r[NUP + 2*N - 2*(N >> lv) + (d >> lv)] = 1'b1;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pend[i] = 0; m_act[i] = 0; m_dst[i] = 0;
      end
      m_busy = '0; m_gnt = '0; m_ptr = N - 1;
    end else begin
      logic [NL-1:0] base;
      logic [N-1:0]  ng;
      int            last;
      base = m_busy;
      for (int i = 0; i < N; i++)
        if (teardown[i] && m_act[i]) base = base & ~m_route(i, m_dst[i]);
      ng = '0;
      last = m_ptr;
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (m_ptr + k) % N;
        if (m_pend[c] && ((m_route(c, m_dst[c]) & base) == '0)) begin
          ng[c] = 1'b1;
          base = base | m_route(c, m_dst[c]);
          last = c;
        end
      end
      for (int i = 0; i < N; i++) begin
        bit take;
        take = req_valid[i] && !m_pend[i] && !m_act[i];
        m_act[i]  = (m_act[i] && !teardown[i]) || ng[i];
        m_pend[i] = (m_pend[i] && !ng[i]) || take;
        if (take) m_dst[i] = int'(req_dst[i*W +: W]);
      end
      m_busy = base;
      m_gnt = ng;
      if (ng != '0) m_ptr = last;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      logic [N-1:0] rdy;
      for (int i = 0; i < N; i++) rdy[i] = !m_pend[i] && !m_act[i];
      chk("R6 model grant", 64'(grant), 64'(m_gnt));
      chk("R3 model link_busy", 64'(link_busy), 64'(m_busy));
      chk("R2 model req_ready", 64'(req_ready), 64'(rdy));
    end
  end

  function automatic logic [NL-1:0] lb(input int a, input int b, input int c,
                                       input int d, input int e, input int f);
    logic [NL-1:0] r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    if (d >= 0) r[d] = 1'b1;
    if (e >= 0) r[e] = 1'b1;
    if (f >= 0) r[f] = 1'b1;
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic post(input int c, input int d);
    req_valid[c] = 1'b1;
    req_dst[c*W +: W] = W'(d);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NL-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk("R1 reset link_busy", 64'(link_busy), 64'(0));
    chk("R1 reset grant", 64'(grant), 64'(0));
    chk("R1 reset req_ready", 64'(req_ready), 64'(8'hFF));

    // Path 0 -> 7 across the root
    post(0, 7); step(); req_valid = '0;
    chk("R2 ready low while waiting", 64'(req_ready[0]), 64'(0));
    chk("R3 no grant on take edge", 64'(grant), 64'(0));
    step();
    chk("R3 grant 0->7", 64'(grant), 64'(8'h01));
    chk("R3 links 0->7", 64'(link_busy), 64'(lb(0, 8, 12, 21, 25, 27)));
    step();
    chk("R8 grant drops", 64'(grant), 64'(0));

    // Request from a concentrator already holding a path
    snap = link_busy;
    post(0, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 held request ignored grant", 64'(grant), 64'(0));
      chk("R2 held request ignored links", 64'(link_busy), 64'(snap));
    end
    req_valid = '0;
    teardown[0] = 1'b1; step(); teardown = '0;
    chk("R7 teardown frees path", 64'(link_busy), 64'(0));
    chk("R7 ready back after teardown", 64'(req_ready[0]), 64'(1));

    // Local request
    post(3, 3); step(); req_valid = '0; step();
    chk("R4 local grant", 64'(grant), 64'(8'h08));
    chk("R4 local no links", 64'(link_busy), 64'(0));
    teardown[3] = 1'b1; step(); teardown = '0;

    // Same-round conflict, last granted = 3 so 1 is visited before 2
    post(1, 0); post(2, 0); step(); req_valid = '0; step();
    chk("R6 one of conflicting pair", 64'(grant), 64'(8'h02));
    chk("R6 winner links", 64'(link_busy), 64'(lb(1, 14, -1, -1, -1, -1)));
    step();
    chk("R5 blocked still waiting", 64'(req_ready[2]), 64'(0));
    chk("R5 blocked no grant", 64'(grant), 64'(0));
    teardown[1] = 1'b1; step(); teardown = '0;
    chk("R5 granted on teardown edge", 64'(grant), 64'(8'h04));
    chk("R5 links swapped", 64'(link_busy), 64'(lb(2, 9, 14, 22, -1, -1)));
    teardown[2] = 1'b1; step(); teardown = '0;
    chk("R7 clear after second teardown", 64'(link_busy), 64'(0));

    // Rotation: last granted = 2, so 3 is visited before 1
    post(1, 0); post(3, 0); step(); req_valid = '0; step();
    chk("R9 rotation picks 3", 64'(grant), 64'(8'h08));
    chk("R9 links of 3->0", 64'(link_busy), 64'(lb(3, 9, 14, 22, -1, -1)));
    step();
    teardown[5] = 1'b1; step(); teardown = '0;
    chk("R7 idle teardown no effect links", 64'(link_busy), 64'(lb(3, 9, 14, 22, -1, -1)));
    chk("R7 idle teardown no grant", 64'(grant), 64'(0));
    teardown[3] = 1'b1; step(); teardown = '0;
    chk("R5 waiting 1 granted", 64'(grant), 64'(8'h02));
    teardown[1] = 1'b1; step(); teardown = '0;

    // Disjoint pair in one round
    post(0, 1); post(1, 0); step(); req_valid = '0; step();
    chk("R6 disjoint both granted", 64'(grant), 64'(8'h03));
    chk("R6 disjoint links", 64'(link_busy), 64'(lb(0, 1, 14, 15, -1, -1)));
    teardown = 8'h03; step(); teardown = '0;
    chk("R7 both freed", 64'(link_busy), 64'(0));

    // Random traffic against the model
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int c = 0; c < N; c++) begin
        req_valid[c] = ($urandom % 3) == 0;
        req_dst[c*W +: W] = W'($urandom % N);
        teardown[c] = ($urandom % 5) == 0;
      end
      step();
    end
    req_valid = '0;
    teardown = '0;
    step();
    finish_run();
  end
endmodule